// File: doc/BRIEF.md
# Lazy Condition-Code Flag Evaluator

This block turns a recorded operation into the processor's condition-code word. The pipeline does not compute flags when an instruction executes. It keeps the operation class, the operand size, the two operands, the result and the multiply high word, and asks this block for the flags only when they are needed. From those inputs and the current code word, the block builds the new word and registers it.

Carry and overflow come from the sign bits of the operands and the result, not from an adder carry-out, so no arithmetic is repeated here. Subtract and compare invert the source operand before the sign rule and invert the carry after it. The copy operation reports its carry in a separate flag bit whose position is a parameter. Multiplies examine the 64-bit product formed from the high word and the result. A bit test reads one selected bit of an operand. A masked writeback merges the new flags into the word, always clears the extend flag, and keeps the zero flag sticky during extended arithmetic.

Top module: `ccs_flag_eval`

## Requirements
- R1: After synchronous reset (rst_n low at a rising edge) ccs_q is 0. Reset takes priority over eval_en.
- R2: Add-type classes (code 0, and unused code 15) follow the sign rule. N (bit 3) is the result sign. For a negative result, V (bit 1) is set when both operand signs are 0 and C (bit 0) is set when both are 1. For a non-negative result, Z (bit 2) is set when the sized result is zero, V is set when both signs are 1, and C is set when either sign is 1.
- R3: op_size 0 evaluates bits 7:0, op_size 1 evaluates bits 15:0, and op_size 2 or 3 evaluates all 32 bits. Bits above the selected size are ignored.
- R4: Subtract (code 1) and compare (code 2) invert src before the sign rule and invert C after it.
- R5: Copy (code 3) applies the sign rule at 32 bits whatever op_size is. Its carry goes to the R flag at bit RFLAG_POS (default 8), and C is produced as 0.
- R6: Move (4), and (5), or (6), xor (7) and the shifts (8, 9, 10) produce only N and Z, with V and C as 0, at 16-bit or 32-bit size. At byte size they use the full sign rule of R2.
- R7: Signed multiply (code 11) forms P = {mof,res}. Z is set when P is 0, N is P[63], and V is set unless mof equals the sign extension of res[31].
- R8: Unsigned multiply (code 12) forms P = {mof,res}. Z is set when P is 0, N is P[63], and V is set when mof is nonzero.
- R9: Bit test (code 13) uses src[4:0] as the bit index into dst. It clears X (bit 4), N and Z in ccs_in, sets N to the selected bit, and sets Z when the selected bit and every lower bit are 0. When ver < 32 it also clears V and C. flag_mask and x_in have no effect on it.
- R10: For every class except bit test and flag-hold, the update mask is flag_mask with bit 4 added. Masked bits take the new flag value, so X always ends at 0, and all other bits keep their value from ccs_in.
- R11: When x_in is 1 and the new Z is 1, Z keeps its value from ccs_in, so extended arithmetic can clear Z but never set it.
- R12: Flag-hold (code 14) passes ccs_in to ccs_q unchanged.
- R13: While eval_en is low, ccs_q holds its value. With eval_en high, ccs_q takes the new word at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eval_en | input | 1 | Load the evaluated word into ccs_q |
| op_class | input | 4 | Recorded operation class code |
| op_size | input | 2 | Operand size: 0 byte, 1 halfword, 2/3 word |
| src | input | DATA_W | Source operand, or bit index for bit test |
| dst | input | DATA_W | Destination operand |
| res | input | DATA_W | Recorded result |
| mof | input | DATA_W | Multiply high word |
| flag_mask | input | CCS_W | Flag bits the operation may update |
| x_in | input | 1 | Extend flag in force for the operation |
| ccs_in | input | CCS_W | Current condition-code word |
| ver | input | VER_W | Processor version number |
| ccs_q | output | CCS_W | Registered new condition-code word |

## Verification
Sign-rule operands are chosen to reach each branch: both signs clear with a negative result (overflow only), both set with a zero result (zero, overflow and carry together), and mixed signs. Junk placed above the byte and halfword boundaries shows whether the size select is honoured. The same operands run under add, subtract, copy and the narrow and wide logic classes, which separates source inversion, carry inversion, the R-flag substitution and the byte fallback. Multiply cases use all-ones, a lone sign bit and a zero product. Bit tests use indices 4, 7 and 31 under versions on both sides of 32. Writeback cases vary the mask, the extend flag and a preloaded zero flag to expose mask merging and the sticky zero.

// File: rtl/ccs_eval_pkg.sv
// Shared definitions for the condition-code evaluator.
// Assumes the low five flag positions below; the R flag position is a
// parameter of the top module.
package ccs_eval_pkg;

    localparam int FLAG_C = 0;
    localparam int FLAG_V = 1;
    localparam int FLAG_Z = 2;
    localparam int FLAG_N = 3;
    localparam int FLAG_X = 4;

    typedef enum logic [3:0] {
        OPC_ADD   = 4'd0,
        OPC_SUB   = 4'd1,
        OPC_CMP   = 4'd2,
        OPC_MCP   = 4'd3,
        OPC_MOVE  = 4'd4,
        OPC_AND   = 4'd5,
        OPC_OR    = 4'd6,
        OPC_XOR   = 4'd7,
        OPC_ASR   = 4'd8,
        OPC_LSR   = 4'd9,
        OPC_LSL   = 4'd10,
        OPC_MULS  = 4'd11,
        OPC_MULU  = 4'd12,
        OPC_BTST  = 4'd13,
        OPC_FLAGS = 4'd14,
        OPC_RSVD  = 4'd15
    } opclass_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRD2 = 2'd3
    } opsize_e;

    // Flags produced by a rule before they are placed in the word.
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
        logic r;
    } flag_set_t;

endpackage

// File: rtl/cce_sign_rule.sv
// Sign-bit flag rule: derives N, Z, V and a carry from operand and result
// signs at byte, halfword or word size. Optional source inversion and carry
// inversion serve subtract; r_mode routes the carry into R instead of C.
// Assumes DATA_W >= 16.
module cce_sign_rule
    import ccs_eval_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst,
    input  logic [DATA_W-1:0] res,
    input  logic [1:0]        size_sel,
    input  logic              invert_src,
    input  logic              invert_c,
    input  logic              r_mode,
    output flag_set_t         flags
);
    localparam int BYTE_MSB = 7;
    localparam int HALF_MSB = 15;
    localparam int WORD_MSB = DATA_W - 1;

    logic [DATA_W-1:0] s_eff;
    logic sb, db, rb, rzero, carry;

    // Select the sign bits and zero test at the chosen size.
    always_comb begin
        s_eff = invert_src ? ~src : src;
        unique case (size_sel)
            SZ_BYTE: begin
                sb    = s_eff[BYTE_MSB];
                db    = dst[BYTE_MSB];
                rb    = res[BYTE_MSB];
                rzero = (res[BYTE_MSB:0] == '0);
            end
            SZ_HALF: begin
                sb    = s_eff[HALF_MSB];
                db    = dst[HALF_MSB];
                rb    = res[HALF_MSB];
                rzero = (res[HALF_MSB:0] == '0);
            end
            default: begin
                sb    = s_eff[WORD_MSB];
                db    = dst[WORD_MSB];
                rb    = res[WORD_MSB];
                rzero = (res == '0);
            end
        endcase
    end

    // Apply the sign rule and place the carry in C or R.
    always_comb begin
        flags   = '0;
        flags.n = rb;
        if (rb) begin
            flags.v = ~sb & ~db;
            carry   = sb & db;
        end else begin
            flags.z = rzero;
            flags.v = sb & db;
            carry   = sb | db;
        end
        carry = carry ^ invert_c;
        if (r_mode) begin
            flags.r = carry;
            flags.c = 1'b0;
        end else begin
            flags.c = carry;
        end
    end

endmodule

// File: rtl/cce_mul_rule.sv
// Multiply flag rule over the double-width product {mof,res}.
// Signed mode: V unless mof is the sign extension of res.
// Unsigned mode: V whenever mof is nonzero.
module cce_mul_rule
    import ccs_eval_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] res,
    input  logic [DATA_W-1:0] mof,
    input  logic              signed_mode,
    output flag_set_t         flags
);
    localparam int PROD_W = 2 * DATA_W;

    logic [PROD_W-1:0] prod;
    logic [DATA_W-1:0] sext;

    // Build the product view and derive the flags from it.
    always_comb begin
        prod    = {mof, res};
        sext    = {DATA_W{res[DATA_W-1]}};
        flags   = '0;
        flags.z = (prod == '0);
        flags.n = prod[PROD_W-1];
        flags.v = signed_mode ? (mof != sext) : (mof != '0);
    end

endmodule

// File: rtl/cce_btst_rule.sv
// Bit-test rule: returns a whole new word built from ccs_in. N is the
// selected bit, Z reports an all-zero field from bit 0 to the selected bit,
// X/N/Z are cleared first and V/C too for versions below VER_LIMIT.
module cce_btst_rule
    import ccs_eval_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CCS_W     = 32,
    parameter int VER_W     = 8,
    parameter int VER_LIMIT = 32,
    localparam int IDX_W    = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] value,
    input  logic [IDX_W-1:0]  idx,
    input  logic [CCS_W-1:0]  ccs_in,
    input  logic [VER_W-1:0]  ver,
    output logic [CCS_W-1:0]  ccs_out
);
    logic sel_bit;
    logic low_any;

    // Scan the field from bit 0 up to and including the index.
    always_comb begin
        sel_bit = value[idx];
        low_any = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i <= int'(idx)) low_any = low_any | value[i];
        end
    end

    // Clear the affected flags and insert the test result.
    always_comb begin
        ccs_out         = ccs_in;
        ccs_out[FLAG_X] = 1'b0;
        ccs_out[FLAG_N] = sel_bit;
        ccs_out[FLAG_Z] = ~low_any;
        if (int'(ver) < VER_LIMIT) begin
            ccs_out[FLAG_V] = 1'b0;
            ccs_out[FLAG_C] = 1'b0;
        end
    end

endmodule

// File: rtl/cce_writeback.sv
// Masked merge of a flag set into the condition-code word. X is always in
// the mask; with x_in set a new Z of 1 is dropped from the mask so Z can
// only be cleared during extended arithmetic.
module cce_writeback
    import ccs_eval_pkg::*;
#(
    parameter int CCS_W     = 32,
    parameter int RFLAG_POS = 8
) (
    input  logic [CCS_W-1:0] ccs_in,
    input  logic [CCS_W-1:0] flag_mask,
    input  logic             x_in,
    input  flag_set_t        flags,
    output logic [CCS_W-1:0] ccs_out
);
    logic [CCS_W-1:0] new_bits;
    logic [CCS_W-1:0] eff_mask;

    // Place the flags at their word positions.
    always_comb begin
        new_bits            = '0;
        new_bits[FLAG_N]    = flags.n;
        new_bits[FLAG_Z]    = flags.z;
        new_bits[FLAG_V]    = flags.v;
        new_bits[FLAG_C]    = flags.c;
        new_bits[RFLAG_POS] = flags.r;
    end

    // Form the update mask and merge.
    always_comb begin
        eff_mask         = flag_mask;
        eff_mask[FLAG_X] = 1'b1;
        if (x_in && flags.z) eff_mask[FLAG_Z] = 1'b0;
        ccs_out = (ccs_in & ~eff_mask) | (new_bits & eff_mask);
    end

endmodule

// File: rtl/ccs_flag_eval.sv
// Lazy condition-code evaluator top. Decodes the operation class, selects
// the matching flag rule, merges through the masked writeback (or the
// bit-test / flag-hold paths) and registers the result when eval_en is set.
// Assumes DATA_W >= 16 and RFLAG_POS outside bits 4:0.
module ccs_flag_eval
    import ccs_eval_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CCS_W     = 32,
    parameter int VER_W     = 8,
    parameter int VER_LIMIT = 32,
    parameter int RFLAG_POS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_en,
    input  logic [3:0]        op_class,
    input  logic [1:0]        op_size,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst,
    input  logic [DATA_W-1:0] res,
    input  logic [DATA_W-1:0] mof,
    input  logic [CCS_W-1:0]  flag_mask,
    input  logic              x_in,
    input  logic [CCS_W-1:0]  ccs_in,
    input  logic [VER_W-1:0]  ver,
    output logic [CCS_W-1:0]  ccs_q
);
    localparam int IDX_W    = $clog2(DATA_W);
    localparam int HALF_MSB = 15;

    opclass_e  opc;
    logic      is_sub, is_mcp, is_mul, is_nz, nz_wide;
    logic [1:0] rule_size;
    flag_set_t sign_flags, mul_flags, nz_flags, sel_flags;
    logic [CCS_W-1:0] wb_ccs, bt_ccs, next_ccs;

    // Classify the operation.
    always_comb begin
        opc     = opclass_e'(op_class);
        is_sub  = (opc == OPC_SUB) || (opc == OPC_CMP);
        is_mcp  = (opc == OPC_MCP);
        is_mul  = (opc == OPC_MULS) || (opc == OPC_MULU);
        is_nz   = (opc >= OPC_MOVE) && (opc <= OPC_LSL);
        nz_wide = (op_size != SZ_BYTE);
        rule_size = is_mcp ? SZ_WORD : op_size;
    end

    cce_sign_rule #(.DATA_W(DATA_W)) u_sign (
        .src        (src),
        .dst        (dst),
        .res        (res),
        .size_sel   (rule_size),
        .invert_src (is_sub),
        .invert_c   (is_sub),
        .r_mode     (is_mcp),
        .flags      (sign_flags)
    );

    cce_mul_rule #(.DATA_W(DATA_W)) u_mul (
        .res         (res),
        .mof         (mof),
        .signed_mode (opc == OPC_MULS),
        .flags       (mul_flags)
    );

    // N/Z-only rule for move, logic and shift at halfword or word size.
    always_comb begin
        nz_flags = '0;
        if (op_size == SZ_HALF) begin
            nz_flags.n = res[HALF_MSB];
            nz_flags.z = (res[HALF_MSB:0] == '0);
        end else begin
            nz_flags.n = res[DATA_W-1];
            nz_flags.z = (res == '0);
        end
    end

    // Pick the flag set for the writeback.
    always_comb begin
        if (is_mul)                sel_flags = mul_flags;
        else if (is_nz && nz_wide) sel_flags = nz_flags;
        else                       sel_flags = sign_flags;
    end

    cce_writeback #(.CCS_W(CCS_W), .RFLAG_POS(RFLAG_POS)) u_wb (
        .ccs_in    (ccs_in),
        .flag_mask (flag_mask),
        .x_in      (x_in),
        .flags     (sel_flags),
        .ccs_out   (wb_ccs)
    );

    cce_btst_rule #(
        .DATA_W(DATA_W), .CCS_W(CCS_W), .VER_W(VER_W), .VER_LIMIT(VER_LIMIT)
    ) u_btst (
        .value   (dst),
        .idx     (src[IDX_W-1:0]),
        .ccs_in  (ccs_in),
        .ver     (ver),
        .ccs_out (bt_ccs)
    );

    // Choose between writeback, bit-test and hold paths.
    always_comb begin
        unique case (opc)
            OPC_FLAGS: next_ccs = ccs_in;
            OPC_BTST:  next_ccs = bt_ccs;
            default:   next_ccs = wb_ccs;
        endcase
    end

    // Output register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       ccs_q <= '0;
        else if (eval_en) ccs_q <= next_ccs;
    end

endmodule

// File: rtl/ccs_flag_eval_chk.sv
// Property checker for ccs_flag_eval, attached with bind below.
module ccs_flag_eval_chk
    import ccs_eval_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CCS_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eval_en,
    input logic [3:0]        op_class,
    input logic [DATA_W-1:0] mof,
    input logic [CCS_W-1:0]  flag_mask,
    input logic              x_in,
    input logic [CCS_W-1:0]  ccs_in,
    input logic [CCS_W-1:0]  ccs_q
);
    logic via_wb;
    logic [CCS_W-1:0] x_bit;

    // Classes that go through the masked writeback.
    always_comb begin
        via_wb = (op_class != OPC_BTST) && (op_class != OPC_FLAGS);
        x_bit  = '0;
        x_bit[FLAG_X] = 1'b1;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_en |=> $stable(ccs_q)); // R13
    AST_X_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_en && op_class != OPC_FLAGS) |=> !ccs_q[FLAG_X]); // R10
    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_en && via_wb) |=>
        (((ccs_q ^ $past(ccs_in)) & ~($past(flag_mask) | x_bit)) == '0)); // R10
    AST_HOLD_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_en && op_class == OPC_FLAGS) |=> (ccs_q == $past(ccs_in))); // R12
    AST_Z_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_en && via_wb && x_in && !ccs_in[FLAG_Z]) |=> !ccs_q[FLAG_Z]); // R11
    AST_MULU_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_en && op_class == OPC_MULU && mof != '0 && flag_mask[FLAG_V])
        |=> ccs_q[FLAG_V]); // R8

endmodule

bind ccs_flag_eval ccs_flag_eval_chk #(.DATA_W(DATA_W), .CCS_W(CCS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .eval_en   (eval_en),
    .op_class  (op_class),
    .mof       (mof),
    .flag_mask (flag_mask),
    .x_in      (x_in),
    .ccs_in    (ccs_in),
    .ccs_q     (ccs_q)
);

// File: tb/test_ccs_flag_eval.sv
module test_ccs_flag_eval;
    import ccs_eval_pkg::*;

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  sz;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] res;
        logic [31:0] mof;
        logic [31:0] mask;
        logic        x;
        logic [31:0] cin;
        logic [7:0]  ver;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam logic [31:0] ALL = 32'h0000_010F;
    localparam int NV = 26;
    localparam vec_t VECS [0:NV-1] = '{
        '{OPC_ADD,  2'd2, 32'h1,        32'h2,        32'h3,        32'h0, ALL, 1'b0, 32'h10,  8'd0,  32'h000, 4'd2},  // R2 plain, X cleared
        '{OPC_ADD,  2'd2, 32'h7FFFFFFF, 32'h1,        32'h80000000, 32'h0, ALL, 1'b0, 32'h0,   8'd0,  32'h00A, 4'd2},  // R2 N,V
        '{OPC_ADD,  2'd2, 32'h80000000, 32'h80000000, 32'h0,        32'h0, ALL, 1'b0, 32'h0,   8'd0,  32'h007, 4'd2},  // R2 Z,V,C
        '{OPC_ADD,  2'd2, 32'hFFFFFFFF, 32'h1,        32'h0,        32'h0, ALL, 1'b0, 32'h0,   8'd0,  32'h005, 4'd2},  // R2 Z,C
        '{OPC_ADD,  2'd0, 32'h7F,       32'h01,       32'h12345680, 32'h0, ALL, 1'b0, 32'h0,   8'd0,  32'h00A, 4'd3},  // R3 byte
        '{OPC_ADD,  2'd1, 32'hFFFF,     32'h1,        32'h00010000, 32'h0, ALL, 1'b0, 32'h0,   8'd0,  32'h005, 4'd3},  // R3 half
        '{OPC_SUB,  2'd2, 32'h1,        32'h1,        32'h0,        32'h0, ALL, 1'b0, 32'h0,   8'd0,  32'h004, 4'd4},  // R4 equal
        '{OPC_SUB,  2'd2, 32'h2,        32'h1,        32'hFFFFFFFF, 32'h0, ALL, 1'b0, 32'h0,   8'd0,  32'h009, 4'd4},  // R4 borrow
        '{OPC_CMP,  2'd0, 32'h01,       32'h80,       32'h7F,       32'h0, ALL, 1'b0, 32'h0,   8'd0,  32'h002, 4'd4},  // R4 byte cmp
        '{OPC_MCP,  2'd0, 32'h80000000, 32'h80000000, 32'h00000080, 32'h0, ALL, 1'b0, 32'h1,   8'd0,  32'h102, 4'd5},  // R5
        '{OPC_MOVE, 2'd1, 32'h0,        32'h0,        32'h00008000, 32'h0, 32'h0C, 1'b0, 32'h3, 8'd0,  32'h00B, 4'd6},  // R6 half
        '{OPC_AND,  2'd2, 32'h80000000, 32'h80000000, 32'h0,        32'h0, ALL, 1'b0, 32'h0,   8'd0,  32'h004, 4'd6},  // R6 word
        '{OPC_LSL,  2'd0, 32'h80,       32'h80,       32'h00000100, 32'h0, ALL, 1'b0, 32'h0,   8'd0,  32'h007, 4'd6},  // R6 byte fallback
        '{OPC_MULS, 2'd2, 32'h0,        32'h0,        32'hFFFFFFFF, 32'hFFFFFFFF, ALL, 1'b0, 32'h0, 8'd0, 32'h008, 4'd7}, // R7 -1
        '{OPC_MULS, 2'd2, 32'h0,        32'h0,        32'h80000000, 32'h0, ALL, 1'b0, 32'h0,   8'd0,  32'h002, 4'd7},  // R7 ovf
        '{OPC_MULS, 2'd2, 32'h0,        32'h0,        32'h0,        32'h0, ALL, 1'b0, 32'h0,   8'd0,  32'h004, 4'd7},  // R7 zero
        '{OPC_MULU, 2'd2, 32'h0,        32'h0,        32'h0,        32'h80000000, ALL, 1'b0, 32'h0, 8'd0, 32'h00A, 4'd8}, // R8
        '{OPC_MULU, 2'd2, 32'h0,        32'h0,        32'h5,        32'h0, ALL, 1'b0, 32'h0,   8'd0,  32'h000, 4'd8},  // R8 fits
        '{OPC_BTST, 2'd2, 32'h4,        32'h10,       32'h0,        32'h0, ALL, 1'b1, 32'h1F,  8'd10, 32'h008, 4'd9},  // R9 old ver
        '{OPC_BTST, 2'd2, 32'h7,        32'h100,      32'h0,        32'h0, 32'h0, 1'b0, 32'h13, 8'd32, 32'h007, 4'd9}, // R9 new ver
        '{OPC_BTST, 2'd2, 32'h3F,       32'h80000000, 32'h0,        32'h0, ALL, 1'b0, 32'h0,   8'd40, 32'h008, 4'd9},  // R9 bit 31
        '{OPC_FLAGS,2'd2, 32'h1,        32'h1,        32'h0,        32'h1, ALL, 1'b1, 32'h15A, 8'd0,  32'h15A, 4'd12}, // R12
        '{OPC_ADD,  2'd2, 32'h0,        32'h0,        32'h0,        32'h0, ALL, 1'b1, 32'h10,  8'd0,  32'h000, 4'd11}, // R11 Z not set
        '{OPC_ADD,  2'd2, 32'h0,        32'h1,        32'h1,        32'h0, ALL, 1'b1, 32'h14,  8'd0,  32'h000, 4'd11}, // R11 Z cleared
        '{OPC_ADD,  2'd2, 32'h0,        32'h0,        32'h0,        32'h0, ALL, 1'b1, 32'h14,  8'd0,  32'h004, 4'd11}, // R11 Z kept
        '{OPC_ADD,  2'd2, 32'h7FFFFFFF, 32'h1,        32'h80000000, 32'h0, 32'h07, 1'b0, 32'hFFFF0008, 8'd0, 32'hFFFF000A, 4'd10} // R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eval_en = 1'b0;
    logic [3:0]  op_class = '0;
    logic [1:0]  op_size = '0;
    logic [31:0] src = '0, dst = '0, res = '0, mof = '0;
    logic [31:0] flag_mask = '0, ccs_in = '0;
    logic        x_in = 1'b0;
    logic [7:0]  ver = '0;
    logic [31:0] ccs_q;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ccs_flag_eval i_ccs_flag_eval (
        .clk(clk), .rst_n(rst_n), .eval_en(eval_en), .op_class(op_class),
        .op_size(op_size), .src(src), .dst(dst), .res(res), .mof(mof),
        .flag_mask(flag_mask), .x_in(x_in), .ccs_in(ccs_in), .ver(ver),
        .ccs_q(ccs_q)
    );

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] want);
        n_checks++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL R%0d: ccs_q=%h expected %h", req, got, want);
        end
    endtask

    task automatic drive(input vec_t v);
        op_class = v.op; op_size = v.sz; src = v.src; dst = v.dst;
        res = v.res; mof = v.mof; flag_mask = v.mask; x_in = v.x;
        ccs_in = v.cin; ver = v.ver;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: ccs_q=%h expected completion", ccs_q);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(1, ccs_q, 32'h0);
        rst_n = 1'b1;

        // Table walk: one evaluation per vector, sampled on the next falling edge.
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(VECS[k]);
            eval_en = 1'b1;
            @(negedge clk);
            eval_en = 1'b0;
            check(int'(VECS[k].req), ccs_q, VECS[k].exp);
        end

        // R13: idle hold with changed inputs (last result FFFF000A)
        @(negedge clk);
        op_class = OPC_FLAGS; ccs_in = 32'h1234_5678; eval_en = 1'b0;
        repeat (2) @(negedge clk);
        check(13, ccs_q, 32'hFFFF000A);

        // R1: reset wins over eval_en
        rst_n = 1'b0; eval_en = 1'b1;
        @(negedge clk);
        check(1, ccs_q, 32'h0);
        rst_n = 1'b1; eval_en = 1'b0;

        // R13: enabled load after reset
        op_class = OPC_FLAGS; ccs_in = 32'h0000_0003; eval_en = 1'b1;
        @(negedge clk);
        eval_en = 1'b0;
        check(13, ccs_q, 32'h3);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule